// File: doc/BRIEF.md
# Staged Link Bring-Up Sequencer

This block starts link training on a serial interconnect port and confirms, stage by stage, that the link has come up. On a start command it raises a training-enable output. It then watches a status word from the link core in three waits. The first wait is for the physical-layer link-up flag. The second is for the data-link-layer link-up flag. The third is for the training state field to settle in an operational range. Between the second and third waits it issues a one-cycle speed-change request, so the link can try rates above the base rate.

Each wait samples the status word once on entry and then once every `POLL_CYC` clock cycles. Each wait gives up after `TIMEOUT_CYC / POLL_CYC` failed samples. A timeout ends the sequence with a failure flag and a code naming the stage that timed out. A stop command clears training enable and abandons the sequence at any point without reporting an error. The training state machine, equalization and rate negotiation all live elsewhere. This block only sequences and checks them.

Top module: `link_bringup_ctrl`

## Requirements
- R1: After reset, train_en_o, speed_req_o, busy_o, done_o and fail_o are 0 and fail_stage_o is 0.
- R2: A start_i sampled while not busy (idle, done or failed) sets train_en_o and busy_o at the next cycle and clears done_o, fail_o and fail_stage_o. A start_i sampled while busy has no effect.
- R3: The first wait advances only on a sample with status_i bit 6 (physical link up) set. Bit 7 alone does not advance it.
- R4: The second wait advances only on a sample with status_i bit 7 (data link up) set.
- R5: speed_req_o is high for exactly one cycle. It rises in the cycle after the second wait succeeds, and the third wait starts in the cycle after that.
- R6: The third wait succeeds only on a sample where status_i[5:0] is between 0x11 and 0x16 inclusive. On success, done_o is set and busy_o is cleared.
- R7: In a wait, status_i is sampled in the first cycle of the stage and then every POLL_CYC cycles. Values present only between samples are ignored.
- R8: If a wait sees TIMEOUT_CYC/POLL_CYC failing samples, the block sets fail_o, clears busy_o and keeps train_en_o set. fail_stage_o then reads 1 for the physical wait, 2 for the data-link wait and 3 for the state-range wait.
- R9: stop_i clears train_en_o, busy_o, done_o, fail_o and fail_stage_o at the next cycle. It takes priority over a start_i in the same cycle and never produces a failure.
- R10: done_o and fail_o hold until the next accepted start_i or a stop_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin the bring-up sequence |
| stop_i | input | 1 | Abort and drop training enable |
| status_i | input | ST_W (8) | Link status: [5:0] training state, [6] physical up, [7] data link up |
| train_en_o | output | 1 | Training enable to the link core |
| speed_req_o | output | 1 | One-cycle speed-change request |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | All three stages passed |
| fail_o | output | 1 | A stage timed out |
| fail_stage_o | output | 2 | Stage that timed out: 0 none, 1 physical, 2 data link, 3 state range |

## Verification
The sequence is driven to success with the data-link flag raised before the physical flag, which separates the stages from one another. The sequence is also driven into a timeout at each of the three stages, which tells the failure codes apart. The state field is held at 0x10, 0x17, 0x16, 0x11 and 0x12 to locate both edges of the accepted range. Single-cycle flag pulses placed between samples show that only sample cycles count. Stop during a wait, stop together with start, and start while busy show that an abort raises no error and that commands are ignored while busy.

// File: rtl/lbm_pkg.sv
package lbm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PHY,
    ST_DL,
    ST_SPD,
    ST_L0,
    ST_DONE,
    ST_FAIL
  } lbm_state_e;

  typedef enum logic [1:0] {
    FS_NONE = 2'd0,
    FS_PHY  = 2'd1,
    FS_DL   = 2'd2,
    FS_L0   = 2'd3
  } lbm_fail_e;
endpackage

// File: rtl/lbm_stage_eval.sv
module lbm_stage_eval
  import lbm_pkg::*;
#(
  parameter int ST_W    = 8,
  parameter int FIELD_W = 6,
  parameter int PHY_BIT = 6,
  parameter int DL_BIT  = 7,
  parameter int L0_LO   = 'h11,
  parameter int L0_HI   = 'h16
) (
  input  logic [ST_W-1:0] status_i,
  input  lbm_state_e      state_i,
  output logic            met_o
);
  logic [FIELD_W-1:0] field;
  logic               in_range;

  assign field    = status_i[FIELD_W-1:0];
  assign in_range = (field >= FIELD_W'(L0_LO)) && (field <= FIELD_W'(L0_HI));

  always_comb begin
    unique case (state_i)
      ST_PHY:  met_o = status_i[PHY_BIT];
      ST_DL:   met_o = status_i[DL_BIT];
      ST_L0:   met_o = in_range;
      default: met_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/lbm_poll_timer.sv
module lbm_poll_timer #(
  parameter int POLL_CYC  = 100000,
  parameter int NUM_POLLS = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  output logic poll_o,
  output logic last_o
);
  localparam int PW = (NUM_POLLS > 1) ? $clog2(NUM_POLLS) : 1;

  logic          at_tick;
  logic [PW-1:0] polls_q;

  generate
    if (POLL_CYC > 1) begin : g_tick
      localparam int TW = $clog2(POLL_CYC);
      logic [TW-1:0] tick_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                 tick_q <= '0;
        else if (!run_i || restart_i) tick_q <= '0;
        else if (tick_q == TW'(POLL_CYC - 1)) tick_q <= '0;
        else                         tick_q <= tick_q + 1'b1;
      end
      assign at_tick = (tick_q == '0);
    end else begin : g_every
      assign at_tick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  polls_q <= '0;
    else if (!run_i || restart_i) polls_q <= '0;
    else if (at_tick && !last_o)  polls_q <= polls_q + 1'b1;
  end

  assign poll_o = run_i & at_tick;
  assign last_o = (polls_q == PW'(NUM_POLLS - 1));
endmodule

// File: rtl/lbm_seq.sv
module lbm_seq
  import lbm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       met_i,
  input  logic       poll_i,
  input  logic       last_i,
  output lbm_state_e state_o,
  output logic       restart_o,
  output logic       train_en_o,
  output logic [1:0] fail_stage_o
);
  lbm_state_e state_q, state_d;
  lbm_fail_e  fs_q, fs_d;
  logic       en_q, en_d;

  always_comb begin
    state_d = state_q;
    fs_d    = fs_q;
    en_d    = en_q;
    if (stop_i) begin
      state_d = ST_IDLE;
      fs_d    = FS_NONE;
      en_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_DONE, ST_FAIL: if (start_i) begin
          state_d = ST_PHY;
          fs_d    = FS_NONE;
          en_d    = 1'b1;
        end
        ST_PHY: if (poll_i) begin
          if (met_i)       state_d = ST_DL;
          else if (last_i) begin state_d = ST_FAIL; fs_d = FS_PHY; end
        end
        ST_DL: if (poll_i) begin
          if (met_i)       state_d = ST_SPD;
          else if (last_i) begin state_d = ST_FAIL; fs_d = FS_DL; end
        end
        ST_SPD: state_d = ST_L0;
        ST_L0: if (poll_i) begin
          if (met_i)       state_d = ST_DONE;
          else if (last_i) begin state_d = ST_FAIL; fs_d = FS_L0; end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      fs_q    <= FS_NONE;
      en_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      fs_q    <= fs_d;
      en_q    <= en_d;
    end
  end

  assign state_o      = state_q;
  assign restart_o    = (state_d != state_q);
  assign train_en_o   = en_q;
  assign fail_stage_o = fs_q;
endmodule

// File: rtl/link_bringup_ctrl.sv
module link_bringup_ctrl
  import lbm_pkg::*;
#(
  parameter int ST_W        = 8,
  parameter int FIELD_W     = 6,
  parameter int PHY_BIT     = 6,
  parameter int DL_BIT      = 7,
  parameter int L0_LO       = 'h11,
  parameter int L0_HI       = 'h16,
  parameter int POLL_CYC    = 100000,
  parameter int TIMEOUT_CYC = 100000000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            stop_i,
  input  logic [ST_W-1:0] status_i,
  output logic            train_en_o,
  output logic            speed_req_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            fail_o,
  output logic [1:0]      fail_stage_o
);
  localparam int NUM_POLLS = (TIMEOUT_CYC / POLL_CYC > 0) ? TIMEOUT_CYC / POLL_CYC : 1;

  lbm_state_e state;
  logic       met, poll, last, restart, run;

  assign run = (state == ST_PHY) || (state == ST_DL) || (state == ST_L0);

  lbm_stage_eval #(
    .ST_W(ST_W), .FIELD_W(FIELD_W), .PHY_BIT(PHY_BIT), .DL_BIT(DL_BIT),
    .L0_LO(L0_LO), .L0_HI(L0_HI)
  ) u_eval (
    .status_i (status_i),
    .state_i  (state),
    .met_o    (met)
  );

  lbm_poll_timer #(
    .POLL_CYC(POLL_CYC), .NUM_POLLS(NUM_POLLS)
  ) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run),
    .restart_i (restart),
    .poll_o    (poll),
    .last_o    (last)
  );

  lbm_seq u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .stop_i       (stop_i),
    .met_i        (met),
    .poll_i       (poll),
    .last_i       (last),
    .state_o      (state),
    .restart_o    (restart),
    .train_en_o   (train_en_o),
    .fail_stage_o (fail_stage_o)
  );

  assign busy_o      = run || (state == ST_SPD);
  assign speed_req_o = (state == ST_SPD);
  assign done_o      = (state == ST_DONE);
  assign fail_o      = (state == ST_FAIL);
endmodule

// File: rtl/lbm_checker.sv
module lbm_checker #(
  parameter int ST_W    = 8,
  parameter int FIELD_W = 6,
  parameter int DL_BIT  = 7,
  parameter int L0_LO   = 'h11,
  parameter int L0_HI   = 'h16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic            stop_i,
  input logic [ST_W-1:0] status_i,
  input logic            train_en_o,
  input logic            speed_req_o,
  input logic            busy_o,
  input logic            done_o,
  input logic            fail_o,
  input logic [1:0]      fail_stage_o
);
  a_r5_req_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    speed_req_o |=> !speed_req_o);

  a_r5_req_after_dl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(speed_req_o) |-> $past(status_i[DL_BIT]));

  a_r5_req_with_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    speed_req_o |-> (train_en_o && busy_o));

  a_r6_done_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(status_i[FIELD_W-1:0]) >= FIELD_W'(L0_LO) &&
                       $past(status_i[FIELD_W-1:0]) <= FIELD_W'(L0_HI)));

  a_r2_start_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !stop_i && !busy_o) |=> (busy_o && train_en_o));

  a_r2_busy_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> train_en_o);

  a_r8_fail_has_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> (fail_stage_o != 2'd0 && train_en_o));

  a_r8_code_only_on_fail: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fail_o |-> (fail_stage_o == 2'd0));

  a_r9_stop_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (!train_en_o && !busy_o && !done_o && !fail_o));

  a_r10_flags_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({busy_o, done_o, fail_o}));
endmodule

bind link_bringup_ctrl lbm_checker #(
  .ST_W(ST_W), .FIELD_W(FIELD_W), .DL_BIT(DL_BIT), .L0_LO(L0_LO), .L0_HI(L0_HI)
) u_lbm_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .stop_i       (stop_i),
  .status_i     (status_i),
  .train_en_o   (train_en_o),
  .speed_req_o  (speed_req_o),
  .busy_o       (busy_o),
  .done_o       (done_o),
  .fail_o       (fail_o),
  .fail_stage_o (fail_stage_o)
);

// File: tb/link_bringup_ctrl_tb_top.sv
`timescale 1ns/1ps
module link_bringup_ctrl_tb_top;
  localparam int P  = 4;
  localparam int T  = 20;
  localparam int NP = T / P;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, stop = 1'b0;
  logic [7:0] status = 8'h00;
  logic       train_en, speed_req, busy, done, fail;
  logic [1:0] fail_stage;

  int    n_vec = 0, n_bad = 0, n_cyc = 0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  link_bringup_ctrl #(.POLL_CYC(P), .TIMEOUT_CYC(T)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop), .status_i(status),
    .train_en_o(train_en), .speed_req_o(speed_req), .busy_o(busy),
    .done_o(done), .fail_o(fail), .fail_stage_o(fail_stage)
  );

  // reference model: 0 idle 1 phy 2 data-link 3 speed 4 range 5 done 6 fail
  int m_st = 0, m_en = 0, m_fs = 0, m_tick = 0, m_polls = 0;

  function automatic bit cond_ok(int st, logic [7:0] s);
    if (st == 1) return s[6];
    if (st == 2) return s[7];
    return (s[5:0] >= 6'h11) && (s[5:0] <= 6'h16);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_en = 0; m_fs = 0; m_tick = 0; m_polls = 0;
    end else if (stop) begin
      m_st = 0; m_en = 0; m_fs = 0;
    end else if (m_st == 0 || m_st == 5 || m_st == 6) begin
      if (start) begin m_st = 1; m_en = 1; m_fs = 0; m_tick = 0; m_polls = 0; end
    end else if (m_st == 3) begin
      m_st = 4; m_tick = 0; m_polls = 0;
    end else if (m_tick == 0) begin
      if (cond_ok(m_st, status)) begin
        m_st = (m_st == 1) ? 2 : (m_st == 2) ? 3 : 5;
        m_tick = 0; m_polls = 0;
      end else if (m_polls == NP - 1) begin
        m_fs = (m_st == 1) ? 1 : (m_st == 2) ? 2 : 3;
        m_st = 6;
      end else begin
        m_polls++;
        m_tick = (P > 1) ? 1 : 0;
      end
    end else begin
      m_tick = (m_tick == P - 1) ? 0 : m_tick + 1;
    end
  end

  task automatic cmp(string what, int act, int exp);
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    n_cyc++;
    n_vec++;
    cmp("train_en",   int'(train_en),   m_en);
    cmp("speed_req",  int'(speed_req),  int'(m_st == 3));
    cmp("busy",       int'(busy),       int'(m_st >= 1 && m_st <= 4));
    cmp("done",       int'(done),       int'(m_st == 5));
    cmp("fail",       int'(fail),       int'(m_st == 6));
    cmp("fail_stage", int'(fail_stage), m_fs);
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    start = 1'b1; cyc(1); start = 1'b0;
  endtask

  task automatic do_stop();
    stop = 1'b1; cyc(1); stop = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  always @(negedge clk) begin
    if (n_cyc > 20000) begin
      n_bad++;
      $display("FAIL R2 watchdog act=%0d cycles exp<=20000", n_cyc);
      summary();
    end
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    cyc(3);
    rst_n = 1'b1;
    cyc(3);
    // R3: data-link flag alone must not advance the physical wait
    cur_req = "R3";
    status = 8'h80;
    do_start();
    cyc(9);
    // R4/R5: physical up, then data link, then one-cycle speed request
    cur_req = "R5";
    status = 8'hC0;
    cyc(8);
    // R6: upper bound of accepted range
    cur_req = "R6";
    status = 8'hC0 | 8'h16;
    cyc(8);
    // R10: done holds
    cur_req = "R10";
    cyc(10);
    // R8: timeout at the physical wait, restart from done (R2)
    cur_req = "R8";
    status = 8'h00;
    do_start();
    cyc(25);
    // R8: timeout at the data-link wait, restart from fail
    status = 8'h40;
    do_start();
    cyc(25);
    // R6: 0x17 is outside the range, timeout at the third wait
    cur_req = "R6";
    status = 8'hC0 | 8'h17;
    do_start();
    cyc(30);
    // R6: 0x10 is outside the range
    status = 8'hC0 | 8'h10;
    do_start();
    cyc(30);
    // R6: lower bound accepted
    status = 8'hC0 | 8'h11;
    do_start();
    cyc(10);
    // R7: one-cycle pulses between samples are ignored
    cur_req = "R7";
    status = 8'h00;
    do_start();
    cyc(2);
    status = 8'h40; cyc(1); status = 8'h00;
    cyc(2);
    status = 8'h40; cyc(1); status = 8'h00;
    cyc(1);
    status = 8'hC0; cyc(1); status = 8'h40;
    cyc(6);
    status = 8'hC0 | 8'h12;
    cyc(10);
    // R9: stop during a wait, no failure
    cur_req = "R9";
    status = 8'h00;
    do_start();
    cyc(5);
    do_stop();
    cyc(4);
    // R9: stop wins over start
    start = 1'b1; stop = 1'b1; cyc(1); start = 1'b0; stop = 1'b0;
    cyc(4);
    // R2: start while busy is ignored
    cur_req = "R2";
    status = 8'h40;
    do_start();
    cyc(3);
    do_start();
    cyc(2);
    do_start();
    cyc(20);
    // R9: stop from fail and from done
    cur_req = "R9";
    do_stop();
    cyc(3);
    status = 8'hC0 | 8'h14;
    do_start();
    cyc(8);
    do_stop();
    cyc(4);
    summary();
  end
endmodule